// File: doc/BRIEF.md
# E1 Alarm Indication Signal Detector

This block watches the recovered bit stream of a 2.048 Mbit/s E1 line and decides whether the far end is sending the all-ones alarm indication signal. A strobe marks each valid received bit. The block counts zero bits inside free-running windows of 512 valid bits, which is 250 µs of line time. The first window starts at reset or at the last change of the mode select.

Two detection policies are offered. In the gated policy, the alarm follows the most recent window: the window must be nearly free of zeros, and the framer must report loss of frame alignment. In the paired policy, two consecutive windows must agree before the alarm is set or cleared. A frame-alignment-found pulse from the framer clears the alarm at once in this policy. A simulation control forces the alarm on for testing. A one-cycle interrupt pulse marks every rising edge of the alarm.

Top module: `e1_ais_detect`

## Requirements
- R1: While reset is applied and until the first window closes, `ais` and `ais_irq` are low.
- R2: A window closes on every 512th clock cycle in which `bit_vld` is high, counted from reset or from the last mode change. Cycles with `bit_vld` low contribute no bit. The alarm state does not change between window closes, except through `fas_found` or `sim_en`.
- R3: With `mode_sel` = 0, a window that holds two or fewer zeros sets `ais` if `lfa` is high during the cycle after the window's last valid bit. `ais` changes on the second rising clock edge after that last bit is sampled.
- R4: With `mode_sel` = 0, a window that holds three or more zeros clears `ais`, and so does any window that closes while `lfa` is low.
- R5: With `mode_sel` = 1, `ais` is set only when two consecutive windows each hold two or fewer zeros. A single such window leaves `ais` unchanged.
- R6: With `mode_sel` = 1, `ais` is cleared only when two consecutive windows each hold three or more zeros. A single busy window, or a busy window followed by a quiet one, leaves a set `ais` unchanged.
- R7: With `mode_sel` = 1, a high `fas_found` clears `ais` on the next rising clock edge.
- R8: `ais_irq` is high for exactly one cycle, in the first cycle in which `ais` is high after having been low. It is never high in any other cycle.
- R9: `sim_en` high forces `ais` high from the next clock edge. When `sim_en` is released, `ais` returns to the alarm state derived from the line.
- R10: Any change of `mode_sel` discards the partly filled window and the record of the previous window, so that a new 512-bit window and a new two-window sequence begin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_vld | input | 1 | Marks a cycle that carries one received bit |
| bit_data | input | 1 | Received data bit, read when `bit_vld` is high |
| lfa | input | 1 | Level from the framer: frame alignment is lost |
| fas_found | input | 1 | Pulse from the framer: frame alignment signal found |
| mode_sel | input | 1 | 0 = gated single-window policy, 1 = paired-window policy |
| sim_en | input | 1 | Alarm simulation: forces the alarm on |
| ais | output | 1 | Alarm indication signal status |
| ais_irq | output | 1 | One-cycle pulse on each rising edge of `ais` |

## Verification
The assertions check on every cycle that the interrupt follows rising edges of the alarm and only those, and that simulation forces the alarm. They also check that the framer's alignment-found pulse clears the alarm in the paired policy, that a gated close with alignment present clears it, and that the status holds steady between window closes. Only the bench scenarios can show the counting behaviour: the 512-bit window length, the two-versus-three zero threshold, bits without a strobe being ignored, the two-window hysteresis, and the restart of windows and history on a mode change. These depend on the content of whole sequences of windows.

// File: rtl/ais_pkg.sv
package ais_pkg;

  typedef enum logic {
    AIS_MODE_GATED  = 1'b0,
    AIS_MODE_PAIRED = 1'b1
  } ais_mode_e;

endpackage

// File: rtl/ais_mode_ctl.sv
module ais_mode_ctl
  import ais_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mode_sel,
  output ais_mode_e mode_q,
  output logic      restart
);

  ais_mode_e mode_d;

  always_comb begin
    restart = (mode_sel != logic'(mode_q));
    mode_d  = mode_q;
    if (restart) begin
      mode_d = ais_mode_e'(mode_sel);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= AIS_MODE_GATED;
    end else begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/ais_window.sv
module ais_window #(
  parameter int WIN_BITS = 512,
  parameter int ZERO_THR = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic bit_vld,
  input  logic bit_data,
  output logic win_done,
  output logic win_quiet
);

  localparam int CNT_W = (WIN_BITS > 1) ? $clog2(WIN_BITS) : 1;
  localparam int ZW    = $clog2(ZERO_THR + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIN_BITS - 1);
  localparam logic [ZW-1:0]    THR      = ZW'(ZERO_THR);

  logic [CNT_W-1:0] bit_cnt_q, bit_cnt_d;
  logic [ZW-1:0]    zero_cnt_q, zero_cnt_d;
  logic [ZW-1:0]    zero_inc;
  logic             done_d;
  logic             quiet_d;
  logic             last_bit;
  logic             cnt_en;

  // saturating zero count including the current bit
  always_comb begin
    zero_inc = zero_cnt_q;
    if (!bit_data && (zero_cnt_q < THR)) begin
      zero_inc = zero_cnt_q + ZW'(1);
    end
  end

  assign last_bit = bit_vld && (bit_cnt_q == LAST_IDX);
  assign cnt_en   = restart || bit_vld;

  always_comb begin
    bit_cnt_d  = bit_cnt_q;
    zero_cnt_d = zero_cnt_q;
    done_d     = 1'b0;
    quiet_d    = win_quiet;
    if (restart) begin
      bit_cnt_d  = '0;
      zero_cnt_d = '0;
    end else if (bit_vld) begin
      if (last_bit) begin
        bit_cnt_d  = '0;
        zero_cnt_d = '0;
        done_d     = 1'b1;
        quiet_d    = (zero_inc < THR);
      end else begin
        bit_cnt_d  = bit_cnt_q + CNT_W'(1);
        zero_cnt_d = zero_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q  <= '0;
      zero_cnt_q <= '0;
    end else if (cnt_en) begin
      bit_cnt_q  <= bit_cnt_d;
      zero_cnt_q <= zero_cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_done  <= 1'b0;
      win_quiet <= 1'b0;
    end else begin
      win_done  <= done_d;
      win_quiet <= quiet_d;
    end
  end

endmodule

// File: rtl/ais_status.sv
module ais_status
  import ais_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ais_mode_e mode_q,
  input  logic      restart,
  input  logic      win_done,
  input  logic      win_quiet,
  input  logic      lfa,
  input  logic      fas_found,
  input  logic      sim_en,
  output logic      ais,
  output logic      ais_irq
);

  logic line_q, line_d;
  logic prev_quiet_q, prev_quiet_d;
  logic prev_vld_q, prev_vld_d;
  logic ais_d;
  logic irq_d;
  logic judge;

  assign judge = win_done && !restart;

  // alarm derived from the line only
  always_comb begin
    line_d = line_q;
    if (judge) begin
      unique case (mode_q)
        AIS_MODE_GATED: begin
          line_d = win_quiet && lfa;
        end
        AIS_MODE_PAIRED: begin
          if (prev_vld_q && prev_quiet_q && win_quiet) begin
            line_d = 1'b1;
          end else if (prev_vld_q && !prev_quiet_q && !win_quiet) begin
            line_d = 1'b0;
          end
        end
        default: line_d = line_q;
      endcase
    end
    if ((mode_q == AIS_MODE_PAIRED) && fas_found) begin
      line_d = 1'b0;
    end
  end

  // one-window history for the paired policy
  always_comb begin
    prev_quiet_d = prev_quiet_q;
    prev_vld_d   = prev_vld_q;
    if (restart) begin
      prev_vld_d   = 1'b0;
      prev_quiet_d = 1'b0;
    end else if (win_done) begin
      prev_vld_d   = 1'b1;
      prev_quiet_d = win_quiet;
    end
  end

  always_comb begin
    ais_d = sim_en || line_d;
    irq_d = ais_d && !ais;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q       <= 1'b0;
      prev_quiet_q <= 1'b0;
      prev_vld_q   <= 1'b0;
    end else begin
      line_q       <= line_d;
      prev_quiet_q <= prev_quiet_d;
      prev_vld_q   <= prev_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ais     <= 1'b0;
      ais_irq <= 1'b0;
    end else begin
      ais     <= ais_d;
      ais_irq <= irq_d;
    end
  end

endmodule

// File: rtl/e1_ais_detect.sv
module e1_ais_detect
  import ais_pkg::*;
#(
  parameter int WIN_BITS = 512,
  parameter int ZERO_THR = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_data,
  input  logic lfa,
  input  logic fas_found,
  input  logic mode_sel,
  input  logic sim_en,
  output logic ais,
  output logic ais_irq
);

  logic      rst_meta_n;
  logic      rst_sync_n;
  ais_mode_e mode_q;
  logic      restart;
  logic      win_done;
  logic      win_quiet;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  ais_mode_ctl u_mode (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mode_sel(mode_sel),
    .mode_q  (mode_q),
    .restart (restart)
  );

  ais_window #(
    .WIN_BITS(WIN_BITS),
    .ZERO_THR(ZERO_THR)
  ) u_win (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .restart  (restart),
    .bit_vld  (bit_vld),
    .bit_data (bit_data),
    .win_done (win_done),
    .win_quiet(win_quiet)
  );

  ais_status u_stat (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .mode_q   (mode_q),
    .restart  (restart),
    .win_done (win_done),
    .win_quiet(win_quiet),
    .lfa      (lfa),
    .fas_found(fas_found),
    .sim_en   (sim_en),
    .ais      (ais),
    .ais_irq  (ais_irq)
  );

endmodule

// File: rtl/e1_ais_detect_chk.sv
module e1_ais_detect_chk (
  input logic clk,
  input logic rst_sync_n,
  input logic mode_q,
  input logic restart,
  input logic win_done,
  input logic lfa,
  input logic fas_found,
  input logic sim_en,
  input logic ais,
  input logic ais_irq
);

  // R8: pulse only while the alarm is up
  a_r8_irq_needs_ais: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ais_irq |-> ais);

  // R8: every rising edge of the alarm carries the pulse
  a_r8_rise_has_irq: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ais) |-> ais_irq);

  // R8: the pulse lasts one cycle
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ais_irq |=> !ais_irq);

  // R9: simulation forces the alarm
  a_r9_sim_forces: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sim_en |=> ais);

  // R7: alignment found clears in the paired policy
  a_r7_fas_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q && fas_found && !sim_en) |=> !ais);

  // R4: gated close with alignment present clears
  a_r4_gated_lfa_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mode_q && win_done && !restart && !lfa && !sim_en) |=> !ais);

  // R2: no change away from window closes
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!win_done && !fas_found && !sim_en && !$past(sim_en)) |=> $stable(ais));

endmodule

bind e1_ais_detect e1_ais_detect_chk u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .mode_q    (mode_q),
  .restart   (restart),
  .win_done  (win_done),
  .lfa       (lfa),
  .fas_found (fas_found),
  .sim_en    (sim_en),
  .ais       (ais),
  .ais_irq   (ais_irq)
);

// File: tb/tb_e1_ais_detect.sv
`timescale 1ns/1ps
module tb_e1_ais_detect;

  localparam int WIN = 512;

  logic clk;
  logic rst_n;
  logic bit_vld;
  logic bit_data;
  logic lfa;
  logic fas_found;
  logic mode_sel;
  logic sim_en;
  logic ais;
  logic ais_irq;

  int n_chk;
  int n_bad;

  e1_ais_detect dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_vld  (bit_vld),
    .bit_data (bit_data),
    .lfa      (lfa),
    .fas_found(fas_found),
    .mode_sel (mode_sel),
    .sim_en   (sim_en),
    .ais      (ais),
    .ais_irq  (ais_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Sends n_bits valid bits, the first nz of them zero.
  task automatic send_bits(input int n_bits, input int nz);
    for (int i = 0; i < n_bits; i++) begin
      @(negedge clk);
      bit_vld  = 1'b1;
      bit_data = (i < nz) ? 1'b0 : 1'b1;
    end
    @(negedge clk);
    bit_vld  = 1'b0;
    bit_data = 1'b1;
  endtask

  // Full window, then sample where the result appears.
  task automatic send_window(input int nz);
    send_bits(WIN, nz);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; bit_vld = 1'b0; bit_data = 1'b1; lfa = 1'b0;
    fas_found = 1'b0; mode_sel = 1'b0; sim_en = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 ais in reset", ais, 1'b0);
    check("R1 irq in reset", ais_irq, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ais after reset", ais, 1'b0);
    check("R1 irq after reset", ais_irq, 1'b0);
  endtask

  task automatic t_gated;
    lfa = 1'b1;
    send_window(2);
    check("R3 two zeros with lfa sets", ais, 1'b1);
    check("R8 irq on rise", ais_irq, 1'b1);
    @(negedge clk);
    check("R8 irq one cycle", ais_irq, 1'b0);
    send_window(3);
    check("R4 three zeros clears", ais, 1'b0);
    lfa = 1'b0;
    send_window(0);
    check("R4 quiet window without lfa stays clear", ais, 1'b0);
    lfa = 1'b1;
    send_window(0);
    check("R3 quiet window with lfa sets", ais, 1'b1);
    lfa = 1'b0;
    send_window(0);
    check("R4 lfa low at close clears", ais, 1'b0);
    lfa = 1'b1;
  endtask

  // Zeros on cycles without the strobe must not count.
  task automatic t_strobe;
    for (int i = 0; i < WIN - 1; i++) begin
      @(negedge clk);
      bit_vld = 1'b1; bit_data = 1'b1;
      if (i % 100 == 0) begin
        @(negedge clk);
        bit_vld = 1'b0; bit_data = 1'b0;
      end
    end
    @(negedge clk);
    bit_vld = 1'b0; bit_data = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 no change before window closes", ais, 1'b0);
    @(negedge clk);
    bit_vld = 1'b1; bit_data = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
    @(negedge clk);
    check("R2 unstrobed zeros ignored", ais, 1'b1);
    send_window(5);
    check("R4 busy window clears", ais, 1'b0);
  endtask

  task automatic t_paired;
    @(negedge clk);
    mode_sel = 1'b1;
    lfa = 1'b0;
    send_window(1);
    check("R5 single quiet window not enough", ais, 1'b0);
    send_window(2);
    check("R5 second quiet window sets", ais, 1'b1);
    check("R8 irq on paired rise", ais_irq, 1'b1);
    send_window(3);
    check("R6 single busy window holds", ais, 1'b1);
    send_window(0);
    check("R6 busy then quiet holds", ais, 1'b1);
    send_window(4);
    check("R6 one busy after quiet holds", ais, 1'b1);
    send_window(9);
    check("R6 two busy windows clear", ais, 1'b0);
    send_window(0);
    send_window(0);
    check("R5 set again", ais, 1'b1);
    @(negedge clk);
    fas_found = 1'b1;
    @(negedge clk);
    fas_found = 1'b0;
    check("R7 alignment found clears", ais, 1'b0);
  endtask

  task automatic t_restart;
    // history currently records a quiet window
    send_bits(300, 0);
    @(negedge clk);
    mode_sel = 1'b0;
    @(negedge clk);
    mode_sel = 1'b1;
    @(negedge clk);
    send_window(0);
    check("R10 history discarded after mode change", ais, 1'b0);
    send_bits(WIN - 1, 0);
    @(negedge clk);
    check("R10 window restarted, no close yet", ais, 1'b0);
    send_bits(1, 0);
    @(negedge clk);
    check("R10 close at 512 bits after restart", ais, 1'b1);
    send_window(3);
    send_window(3);
    check("R6 cleared before simulation test", ais, 1'b0);
  endtask

  task automatic t_sim;
    @(negedge clk);
    sim_en = 1'b1;
    @(negedge clk);
    check("R9 simulation forces alarm", ais, 1'b1);
    check("R8 irq on simulated rise", ais_irq, 1'b1);
    @(negedge clk);
    sim_en = 1'b0;
    @(negedge clk);
    check("R9 release without real alarm clears", ais, 1'b0);
    send_window(0);
    send_window(0);
    check("R5 real alarm before simulation", ais, 1'b1);
    @(negedge clk);
    sim_en = 1'b1;
    @(negedge clk);
    check("R8 no irq when already high", ais_irq, 1'b0);
    sim_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 release keeps real alarm", ais, 1'b1);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    t_reset();
    t_gated();
    t_strobe();
    t_paired();
    t_restart();
    t_sim();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule